// File: doc/BRIEF.md
# Fan Start-Up and Stall Supervisor

This block decides when a pulse-width-modulated fan drive may run, when it must be forced fully on, and when the fan is declared stalled. It watches a tachometer or commutation pulse from the motor and counts PWM periods through a period tick. From these it sequences a forced-on kick-start after reset or shutdown, normal running with a missing-pulse watchdog, a short forced-on diagnostic retry, a longer forced-on restart, and finally a latched stall fault.

The raw sense line is synchronised and edge-detected inside the block. Edges that arrive within a short window after the PWM output switches on are discarded, because they are switching noise and not rotation. A shutdown request overrides everything. It is also the only way out of the stall fault, and releasing it begins the kick-start again. An over-temperature flag pulls the fault output low while the fan runs normally, without latching and without stopping the fan.

Top module: `fan_supervisor`

## Requirements
- R1: While `rst` is high, the outputs are `force_on`=0, `pwm_enable`=0 and `fault_n`=1. On the first clock edge after reset is released, or after a shutdown request is released, the block enters a forced-on start-up window (`force_on`=1, `pwm_enable`=1) that lasts STARTUP_PERIODS (32) period ticks.
- R2: A rising edge on `sense_in` is accepted on the third clock edge after the input goes high. An accepted edge during either start-up window ends forcing: the next outputs are `force_on`=0 and `pwm_enable`=1 (normal running).
- R3: If the first start-up window expires without an accepted edge, a second 32-tick forced-on window follows. When that window also expires, the block enters the stall fault. Stall fault outputs are `force_on`=0, `pwm_enable`=0 and `fault_n`=0.
- R4: In normal running, each accepted edge restarts the missing-pulse count. The 32nd tick without an edge starts a forced-on diagnostic window of DIAG_PERIODS (3) ticks.
- R5: An expired diagnostic window leads to a 32-tick forced-on restart window. If the restart window expires, the block enters the stall fault. An accepted edge during the diagnostic or restart window returns the block to normal running.
- R6: The stall fault holds until a shutdown request is asserted and then released. Sense edges do not release it. On release the block starts again as in R1.
- R7: A sense rising edge is discarded if it is detected in the cycle of `pwm_on_strobe` or in any of the BLANK_CLKS (4) cycles after it. A rising edge detected in the following cycle is accepted.
- R8: A shutdown request overrides every state. On the next edge the outputs become `force_on`=0, `pwm_enable`=0 and `fault_n`=1. All period counting restarts from zero.
- R9: In normal running, `over_temp` drives `fault_n` low one edge later while `pwm_enable` stays 1. Clearing it returns `fault_n` to 1. Outside normal running, `over_temp` has no effect.
- R10: If an accepted edge and the expiring tick of a window fall in the same cycle, the edge wins and the block goes to normal running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sense_in | input | 1 | Raw fan rotation pulse, asynchronous |
| period_tick | input | 1 | One-cycle strobe per PWM period |
| pwm_on_strobe | input | 1 | One-cycle strobe when the PWM output turns on |
| over_temp | input | 1 | Over-temperature flag |
| shutdown_req | input | 1 | Shutdown request, level |
| force_on | output | 1 | Request to drive the PWM at full duty |
| pwm_enable | output | 1 | PWM output allowed |
| fault_n | output | 1 | Active-low fault indication |

## Verification
Two events can meet in one cycle: a window expiring on its final period tick, and a fan edge being accepted. The bench runs the second start-up window to its last tick. It raises the sense line two cycles before that tick so that the detected edge and the tick reach the same clock edge. The block must show normal-running outputs rather than the fault. A second collision sets the turn-on strobe against a sense edge. Edges placed just inside and just outside the blanking window must be rejected and accepted, respectively.

// File: rtl/fan_sup_pkg.sv
package fan_sup_pkg;

  typedef enum logic [2:0] {
    ST_RESET_IDLE = 3'd0,
    ST_STARTUP1   = 3'd1,
    ST_STARTUP2   = 3'd2,
    ST_NORMAL     = 3'd3,
    ST_DIAG       = 3'd4,
    ST_RESTART    = 3'd5,
    ST_FAULT      = 3'd6,
    ST_SHUTDOWN   = 3'd7
  } fan_state_e;

  function automatic logic state_forces(fan_state_e s);
    return (s == ST_STARTUP1) || (s == ST_STARTUP2) ||
           (s == ST_DIAG) || (s == ST_RESTART);
  endfunction

  function automatic logic state_drives(fan_state_e s);
    return state_forces(s) || (s == ST_NORMAL);
  endfunction

endpackage

// File: rtl/fan_sense_edge.sv
module fan_sense_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sense_async,
  output logic rise
);
  // pipe[SYNC_STAGES-1] is the synchronised level, pipe[SYNC_STAGES] its previous value
  logic [SYNC_STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[SYNC_STAGES-1:0], sense_async};
  end

  assign rise = pipe[SYNC_STAGES-1] & ~pipe[SYNC_STAGES];
endmodule

// File: rtl/fan_blank.sv
module fan_blank #(
  parameter int BLANK_CLKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  output logic blank
);
  localparam int BW = $clog2(BLANK_CLKS + 1);
  logic [BW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst)                left_q <= '0;
    else if (strobe)        left_q <= BW'(BLANK_CLKS);
    else if (left_q != '0)  left_q <= left_q - 1'b1;
  end

  assign blank = strobe | (left_q != '0);
endmodule

// File: rtl/fan_period_timer.sv
module fan_period_timer #(
  parameter int MAX_PERIODS = 32,
  localparam int TW = $clog2(MAX_PERIODS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          tick,
  input  logic [TW-1:0] limit,
  output logic          done
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt_q <= '0;
    else if (tick)    cnt_q <= cnt_q + 1'b1;
  end

  // the limit-th tick since the last clear ends the window
  assign done = tick && (cnt_q == limit - 1'b1);
endmodule

// File: rtl/fan_supervisor.sv
module fan_supervisor
  import fan_sup_pkg::*;
#(
  parameter int STARTUP_PERIODS = 32,
  parameter int MISS_PERIODS    = 32,
  parameter int DIAG_PERIODS    = 3,
  parameter int BLANK_CLKS      = 4,
  parameter int SYNC_STAGES     = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sense_in,
  input  logic period_tick,
  input  logic pwm_on_strobe,
  input  logic over_temp,
  input  logic shutdown_req,
  output logic force_on,
  output logic pwm_enable,
  output logic fault_n
);
  localparam int MAX_A = (STARTUP_PERIODS > MISS_PERIODS) ? STARTUP_PERIODS : MISS_PERIODS;
  localparam int MAX_P = (MAX_A > DIAG_PERIODS) ? MAX_A : DIAG_PERIODS;
  localparam int TW    = $clog2(MAX_P + 1);

  fan_state_e state_q, state_d;
  logic       rise, blank, pulse_ok, win_done, cnt_clear;
  logic [TW-1:0] limit;

  fan_sense_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .sense_async(sense_in), .rise(rise));

  fan_blank #(.BLANK_CLKS(BLANK_CLKS)) u_blank (
    .clk(clk), .rst(rst), .strobe(pwm_on_strobe), .blank(blank));

  assign pulse_ok = rise & ~blank;

  always_comb begin
    case (state_q)
      ST_NORMAL: limit = TW'(MISS_PERIODS);
      ST_DIAG:   limit = TW'(DIAG_PERIODS);
      default:   limit = TW'(STARTUP_PERIODS);
    endcase
  end

  fan_period_timer #(.MAX_PERIODS(MAX_P)) u_timer (
    .clk(clk), .rst(rst), .clear(cnt_clear), .tick(period_tick),
    .limit(limit), .done(win_done));

  always_comb begin
    state_d = state_q;
    if (shutdown_req) begin
      state_d = ST_SHUTDOWN;
    end else begin
      case (state_q)
        ST_RESET_IDLE, ST_SHUTDOWN: state_d = ST_STARTUP1;
        ST_STARTUP1: if (pulse_ok) state_d = ST_NORMAL;
                     else if (win_done) state_d = ST_STARTUP2;
        ST_STARTUP2: if (pulse_ok) state_d = ST_NORMAL;
                     else if (win_done) state_d = ST_FAULT;
        ST_NORMAL:   if (!pulse_ok && win_done) state_d = ST_DIAG;
        ST_DIAG:     if (pulse_ok) state_d = ST_NORMAL;
                     else if (win_done) state_d = ST_RESTART;
        ST_RESTART:  if (pulse_ok) state_d = ST_NORMAL;
                     else if (win_done) state_d = ST_FAULT;
        ST_FAULT:    state_d = ST_FAULT;
        default:     state_d = ST_RESET_IDLE;
      endcase
    end
  end

  assign cnt_clear = (state_d != state_q) || ((state_q == ST_NORMAL) && pulse_ok);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_RESET_IDLE;
      force_on   <= 1'b0;
      pwm_enable <= 1'b0;
      fault_n    <= 1'b1;
    end else begin
      state_q    <= state_d;
      force_on   <= state_forces(state_d);
      pwm_enable <= state_drives(state_d);
      fault_n    <= !((state_d == ST_FAULT) || ((state_d == ST_NORMAL) && over_temp));
    end
  end
endmodule

// File: rtl/fan_supervisor_checker.sv
module fan_supervisor_checker
  import fan_sup_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       shutdown_req,
  input logic       pwm_on_strobe,
  input logic       force_on,
  input logic       pwm_enable,
  input logic       fault_n,
  input logic [2:0] state
);
  // R1
  force_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    force_on |-> pwm_enable);

  // R8
  shutdown_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    shutdown_req |=> (!pwm_enable && !force_on && fault_n));

  // R6
  fault_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FAULT && !shutdown_req) |=> (state == ST_FAULT));

  // R3
  fault_outputs_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FAULT) |-> (!fault_n && !pwm_enable && !force_on));

  // R7
  blank_window_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STARTUP1 && pwm_on_strobe && !shutdown_req) |=> (state != ST_NORMAL));

  // R9
  normal_runs_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_NORMAL) |-> (pwm_enable && !force_on));
endmodule

bind fan_supervisor fan_supervisor_checker u_chk (
  .clk(clk), .rst(rst), .shutdown_req(shutdown_req), .pwm_on_strobe(pwm_on_strobe),
  .force_on(force_on), .pwm_enable(pwm_enable), .fault_n(fault_n), .state(state_q));

// File: tb/fan_supervisor_tb.sv
module fan_supervisor_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sense_in = 1'b0, period_tick = 1'b0, pwm_on_strobe = 1'b0;
  logic over_temp = 1'b0, shutdown_req = 1'b0;
  logic force_on, pwm_enable, fault_n;
  int n_chk = 0, n_bad = 0;

  // {force_on, pwm_enable, fault_n}
  localparam logic [2:0] O_IDLE = 3'b001, O_FORCED = 3'b111, O_NORM = 3'b011,
                         O_FAULT = 3'b000, O_OT = 3'b010;

  fan_supervisor u_dut (
    .clk(clk), .rst(rst), .sense_in(sense_in), .period_tick(period_tick),
    .pwm_on_strobe(pwm_on_strobe), .over_temp(over_temp), .shutdown_req(shutdown_req),
    .force_on(force_on), .pwm_enable(pwm_enable), .fault_n(fault_n));

  always #5 clk = ~clk;

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic expect_out(string req, logic [2:0] exp);
    logic [2:0] act;
    act = {force_on, pwm_enable, fault_n};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: outputs=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic ticks(int n);
    repeat (n) begin period_tick = 1'b1; step(); period_tick = 1'b0; step(); end
  endtask

  task automatic fan_pulse();
    sense_in = 1'b1; step(3); sense_in = 1'b0; step(3);
  endtask

  task automatic do_reset();
    rst = 1'b1; shutdown_req = 1'b0; over_temp = 1'b0; sense_in = 1'b0;
    step(3); rst = 1'b0; step();
  endtask

  task automatic t_reset_startup();
    rst = 1'b1; step(3);
    expect_out("R1 reset state", O_IDLE);
    rst = 1'b0; step();
    expect_out("R1 startup forced", O_FORCED);
    fan_pulse();
    expect_out("R2 pulse ends startup", O_NORM);
  endtask

  task automatic t_double_fail();
    do_reset();
    ticks(63);
    expect_out("R3 second window still forced", O_FORCED);
    ticks(1);
    expect_out("R3 stall fault", O_FAULT);
    fan_pulse();
    expect_out("R6 pulse ignored in fault", O_FAULT);
    shutdown_req = 1'b1; step();
    expect_out("R8 shutdown from fault", O_IDLE);
    shutdown_req = 1'b0; step();
    expect_out("R6 release restarts", O_FORCED);
  endtask

  task automatic t_second_window_pulse();
    do_reset(); ticks(40); fan_pulse();
    expect_out("R2 pulse in second window", O_NORM);
  endtask

  task automatic t_missing_pulse();
    do_reset(); fan_pulse();
    ticks(31); fan_pulse(); ticks(31);
    expect_out("R4 pulse restarted count", O_NORM);
    ticks(1);
    expect_out("R4 diag forced", O_FORCED);
    ticks(3 + 31);
    expect_out("R5 restart still forced", O_FORCED);
    ticks(1);
    expect_out("R5 restart expiry faults", O_FAULT);
  endtask

  task automatic t_diag_recover();
    do_reset(); fan_pulse(); ticks(33); fan_pulse();
    expect_out("R5 pulse in diag", O_NORM);
    ticks(35); fan_pulse();
    expect_out("R5 pulse in restart", O_NORM);
  endtask

  task automatic t_blanking();
    do_reset();
    pwm_on_strobe = 1'b1; step(); pwm_on_strobe = 1'b0; step();
    fan_pulse();
    expect_out("R7 edge in last blank cycle dropped", O_FORCED);
    pwm_on_strobe = 1'b1; step(); pwm_on_strobe = 1'b0; step(2);
    fan_pulse();
    expect_out("R7 edge after blank accepted", O_NORM);
  endtask

  task automatic t_shutdown_timers();
    do_reset(); ticks(20);
    shutdown_req = 1'b1; step();
    expect_out("R8 shutdown in startup", O_IDLE);
    fan_pulse();
    expect_out("R8 shutdown holds", O_IDLE);
    shutdown_req = 1'b0; step();
    expect_out("R1 forced after release", O_FORCED);
    ticks(63);
    expect_out("R8 counting restarted", O_FORCED);
    ticks(1);
    expect_out("R3 fault after full windows", O_FAULT);
  endtask

  task automatic t_over_temp();
    do_reset();
    over_temp = 1'b1; step();
    expect_out("R9 no effect in startup", O_FORCED);
    fan_pulse();
    expect_out("R9 fault_n low in normal", O_OT);
    ticks(5);
    expect_out("R9 fan keeps running", O_OT);
    over_temp = 1'b0; step();
    expect_out("R9 does not latch", O_NORM);
  endtask

  task automatic t_collision();
    do_reset(); ticks(32 + 31);
    sense_in = 1'b1; step(2);
    period_tick = 1'b1; step(); period_tick = 1'b0; sense_in = 1'b0;
    expect_out("R10 edge beats expiry", O_NORM);
  endtask

  initial begin
    t_reset_startup();
    t_double_fail();
    t_second_window_pulse();
    t_missing_pulse();
    t_diag_recover();
    t_blanking();
    t_shutdown_timers();
    t_over_temp();
    t_collision();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule